// File: doc/BRIEF.md
# NaN Format Converter

This unit moves a NaN operand between the half, single and double precision IEEE binary formats. The source operand is decoded in its own format, and its fraction is placed, left-aligned, into a 64-bit canonical payload together with the sign. The destination encoding is then built from the most significant fraction bits of that payload. Payload bits below the destination fraction width are dropped, and narrower sources are padded with zeros on the right.

A floating-point pipeline places this unit between operand fetch and writeback whenever a conversion operation meets a NaN. Two cases give the destination's fixed default NaN instead of the carried payload: a default-NaN mode input, and a payload that truncates to zero. A signaling source raises an invalid pulse in the same cycle as the result, and an outside status register accumulates it. Operands that are not NaN pass through untouched.

An optional output register, selected by a parameter, gives a one-cycle result. It is enabled by default.

Top module: `nan_fmt_conv`

## Requirements
- R1: `is_nan` is high exactly when the source exponent field is all ones and its fraction is nonzero. Format codes select the source layout: 0 is half (bits 15:0, exponent 14:10), 1 is single (bits 31:0, exponent 30:23), 2 is double (bits 63:0, exponent 62:52), and 3 is decoded as double.
- R2: `invalid` is high exactly when the source is a signaling NaN, meaning a NaN whose top fraction bit is 0. It is a per-result pulse with no memory of earlier operands.
- R3: A source that is not a NaN is returned on `res_val` as the full 64-bit input value, with `invalid` and `is_nan` low. This holds in any mode and for any destination code.
- R4: For a NaN source in normal mode, the result carries the source sign, an all-ones destination exponent, and as fraction the top destination-width bits of the left-aligned source fraction. Output bits above the destination width are zero.
- R5: The quiet bit is never forced. A signaling source whose payload survives truncation yields a signaling result.
- R6: If the destination fraction taken from the payload is zero, the result is the destination default NaN: 0x7E00 for half, 0x7FC00000 for single, 0x7FF8000000000000 for double.
- R7: When `dflt_mode` is high, every NaN source yields the destination default NaN. `invalid` still follows R2.
- R8: With `OUT_REG=1`, results appear one clock after their inputs. Synchronous reset clears all three outputs to zero.
- R9: Whenever `is_nan` is high, `res_val` is itself a NaN in the destination format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_val | input | 64 | Source operand, right-justified |
| src_fmt | input | 2 | Source format code |
| dst_fmt | input | 2 | Destination format code |
| dflt_mode | input | 1 | Force default NaN for NaN sources |
| res_val | output | 64 | Converted value, zero-extended |
| invalid | output | 1 | Signaling-NaN pulse |
| is_nan | output | 1 | Source was a NaN |

## Verification
With the default output register, `res_val`, `invalid` and `is_nan` are all due one clock after the inputs that produce them. The bench changes inputs on a falling edge, lets exactly one rising edge pass, and samples on the next falling edge. Each check therefore sees only the result of the vector just applied. The checker keeps one-cycle delayed copies of the inputs, so it can compare every output against the stimulus that produced it.

// File: rtl/nan_fmt_pkg.sv
package nan_fmt_pkg;

    localparam int WORD_W  = 64;
    localparam int CANON_W = 64;
    localparam int NUM_FMT = 3;
    localparam int IDX_W   = $clog2(NUM_FMT);

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2,
        FMT_RSVD   = 2'd3
    } fmt_e;

    typedef struct packed {
        logic               sign;
        logic [CANON_W-1:0] payload;
    } canon_t;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
    } class_t;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              invalid;
        logic              is_nan;
    } result_t;

    function automatic int exp_bits(int idx);
        case (idx)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic int frac_bits(int idx);
        case (idx)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

    // reserved code decodes as double
    function automatic logic [IDX_W-1:0] fmt_index(fmt_e f);
        case (f)
            FMT_HALF:   return IDX_W'(0);
            FMT_SINGLE: return IDX_W'(1);
            default:    return IDX_W'(2);
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] default_nan(logic [IDX_W-1:0] idx);
        case (idx)
            IDX_W'(0): return WORD_W'(16'h7E00);
            IDX_W'(1): return WORD_W'(32'h7FC0_0000);
            default:   return 64'h7FF8_0000_0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/nan_classify.sv
module nan_classify
    import nan_fmt_pkg::*;
#(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic [EW+FW:0] word,
    output class_t         cls,
    output logic           sign,
    output logic [FW-1:0]  frac
);
    logic [EW-1:0] expo;

    always_comb begin
        expo        = word[EW+FW-1:FW];
        frac        = word[FW-1:0];
        sign        = word[EW+FW];
        cls.is_nan  = (&expo) && (|frac);
        cls.is_snan = (&expo) && (|frac) && !frac[FW-1];
    end
endmodule

// File: rtl/nan_unpack.sv
module nan_unpack
    import nan_fmt_pkg::*;
#(
    parameter int FW = 23
) (
    input  logic          sign,
    input  logic [FW-1:0] frac,
    output canon_t        canon
);
    localparam int PAD_W = CANON_W - FW;

    always_comb begin
        canon.sign    = sign;
        canon.payload = {frac, {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/nan_pack.sv
module nan_pack
    import nan_fmt_pkg::*;
#(
    parameter int IDX = 1,
    parameter int EW  = 8,
    parameter int FW  = 23
) (
    input  logic              sign,
    input  logic [FW-1:0]     top_frac,
    input  logic              dflt_mode,
    output logic [WORD_W-1:0] value
);
    localparam int              TOT_W = EW + FW + 1;
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(IDX);

    logic [TOT_W-1:0] built;

    always_comb begin
        built = {sign, {EW{1'b1}}, top_frac};
        if (dflt_mode || (top_frac == '0)) begin
            value = default_nan(MY_IDX);
        end else begin
            value = WORD_W'(built);
        end
    end
endmodule

// File: rtl/nan_fmt_conv.sv
module nan_fmt_conv
    import nan_fmt_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] src_val,
    input  logic [1:0]  src_fmt,
    input  logic [1:0]  dst_fmt,
    input  logic        dflt_mode,
    output logic [63:0] res_val,
    output logic        invalid,
    output logic        is_nan
);
    class_t            cls_arr   [NUM_FMT];
    canon_t            canon_arr [NUM_FMT];
    logic [WORD_W-1:0] packed_arr[NUM_FMT];

    logic [IDX_W-1:0]  src_idx;
    logic [IDX_W-1:0]  dst_idx;
    canon_t            canon_sel;
    class_t            cls_sel;
    result_t           nxt;

    assign src_idx   = fmt_index(fmt_e'(src_fmt));
    assign dst_idx   = fmt_index(fmt_e'(dst_fmt));
    assign canon_sel = canon_arr[src_idx];
    assign cls_sel   = cls_arr[src_idx];

    for (genvar i = 0; i < NUM_FMT; i++) begin : g_fmt
        localparam int EW_I = exp_bits(i);
        localparam int FW_I = frac_bits(i);

        logic            sgn_i;
        logic [FW_I-1:0] frac_i;

        nan_classify #(.EW(EW_I), .FW(FW_I)) u_cls (
            .word (src_val[EW_I+FW_I:0]),
            .cls  (cls_arr[i]),
            .sign (sgn_i),
            .frac (frac_i)
        );

        nan_unpack #(.FW(FW_I)) u_unp (
            .sign  (sgn_i),
            .frac  (frac_i),
            .canon (canon_arr[i])
        );

        nan_pack #(.IDX(i), .EW(EW_I), .FW(FW_I)) u_pck (
            .sign      (canon_sel.sign),
            .top_frac  (canon_sel.payload[CANON_W-1 -: FW_I]),
            .dflt_mode (dflt_mode),
            .value     (packed_arr[i])
        );
    end

    always_comb begin
        nxt.is_nan  = cls_sel.is_nan;
        nxt.invalid = cls_sel.is_snan;
        nxt.value   = cls_sel.is_nan ? packed_arr[dst_idx] : src_val;
    end

    if (OUT_REG) begin : g_reg
        result_t q;
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= nxt;
        end
        assign res_val = q.value;
        assign invalid = q.invalid;
        assign is_nan  = q.is_nan;
    end else begin : g_comb
        assign res_val = nxt.value;
        assign invalid = nxt.invalid;
        assign is_nan  = nxt.is_nan;
    end
endmodule

// File: rtl/nan_fmt_conv_chk.sv
module nan_fmt_conv_chk
    import nan_fmt_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic [63:0] src_val,
    input logic [1:0]  dst_fmt,
    input logic        dflt_mode,
    input logic [63:0] res_val,
    input logic        invalid,
    input logic        is_nan
);
    logic [63:0] a_src;
    logic [1:0]  a_dst;
    logic        a_dflt;
    logic        a_vld;

    if (OUT_REG) begin : g_dly
        always_ff @(posedge clk) begin
            if (rst) begin
                a_src  <= '0;
                a_dst  <= '0;
                a_dflt <= 1'b0;
                a_vld  <= 1'b0;
            end else begin
                a_src  <= src_val;
                a_dst  <= dst_fmt;
                a_dflt <= dflt_mode;
                a_vld  <= 1'b1;
            end
        end

        // R8: outputs cleared in the cycle after reset
        a_r8_reset_clear: assert property (@(posedge clk)
            $past(rst) |-> (res_val == '0 && !invalid && !is_nan));
    end else begin : g_now
        assign a_src  = src_val;
        assign a_dst  = dst_fmt;
        assign a_dflt = dflt_mode;
        assign a_vld  = 1'b1;
    end

    function automatic logic dst_is_nan(logic [63:0] v, logic [1:0] f);
        case (fmt_index(fmt_e'(f)))
            IDX_W'(0): return (&v[14:10]) && (|v[9:0])  && (v[63:16] == '0);
            IDX_W'(1): return (&v[30:23]) && (|v[22:0]) && (v[63:32] == '0);
            default:   return (&v[62:52]) && (|v[51:0]);
        endcase
    endfunction

    a_r2_invalid_only_nan: assert property (@(posedge clk) disable iff (rst)
        invalid |-> is_nan);

    a_r3_passthrough: assert property (@(posedge clk) disable iff (rst)
        (a_vld && !is_nan) |-> (res_val == a_src && !invalid));

    a_r7_default_mode: assert property (@(posedge clk) disable iff (rst)
        (a_vld && is_nan && a_dflt) |->
            (res_val == default_nan(fmt_index(fmt_e'(a_dst)))));

    a_r9_result_is_nan: assert property (@(posedge clk) disable iff (rst)
        (a_vld && is_nan) |-> dst_is_nan(res_val, a_dst));
endmodule

bind nan_fmt_conv nan_fmt_conv_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_val   (src_val),
    .dst_fmt   (dst_fmt),
    .dflt_mode (dflt_mode),
    .res_val   (res_val),
    .invalid   (invalid),
    .is_nan    (is_nan)
);

// File: tb/sim_nan_fmt_conv.sv
`timescale 1ns/1ps
module sim_nan_fmt_conv;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_val = '0;
    logic [1:0]  src_fmt = '0;
    logic [1:0]  dst_fmt = '0;
    logic        dflt_mode = 1'b0;
    logic [63:0] res_val;
    logic        invalid;
    logic        is_nan;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    nan_fmt_conv u0 (
        .clk(clk), .rst(rst), .src_val(src_val), .src_fmt(src_fmt),
        .dst_fmt(dst_fmt), .dflt_mode(dflt_mode),
        .res_val(res_val), .invalid(invalid), .is_nan(is_nan)
    );

    function automatic int b_ew(logic [1:0] f);
        return (f == 2'd0) ? 5 : (f == 2'd1) ? 8 : 11;
    endfunction
    function automatic int b_fw(logic [1:0] f);
        return (f == 2'd0) ? 10 : (f == 2'd1) ? 23 : 52;
    endfunction
    function automatic logic [63:0] b_mask(int n);
        return (64'd1 << n) - 64'd1;
    endfunction
    function automatic logic [63:0] b_dnan(logic [1:0] f);
        return (f == 2'd0) ? 64'h7E00 : (f == 2'd1) ? 64'h7FC0_0000
                                                    : 64'h7FF8_0000_0000_0000;
    endfunction

    // returns {value, invalid, is_nan}
    function automatic logic [65:0] model(logic [63:0] v, logic [1:0] sf,
                                          logic [1:0] df, logic dm);
        int          sew = b_ew(sf);
        int          sfw = b_fw(sf);
        int          dew = b_ew(df);
        int          dfw = b_fw(df);
        logic [63:0] ex  = (v >> sfw) & b_mask(sew);
        logic [63:0] fr  = v & b_mask(sfw);
        logic        sg  = v[sew + sfw];
        logic        nan = (ex == b_mask(sew)) && (fr != 0);
        logic        snn = nan && !fr[sfw-1];
        logic [63:0] nf;
        logic [63:0] out;
        if (!nan) return {v, 1'b0, 1'b0};
        nf = (dfw >= sfw) ? (fr << (dfw - sfw)) : (fr >> (sfw - dfw));
        if (dm || nf == 0) out = b_dnan(df);
        else out = (64'(sg) << (dew + dfw)) | (b_mask(dew) << dfw) | nf;
        return {out, snn, 1'b1};
    endfunction

    task automatic check(string req, logic [65:0] exp);
        checks++;
        if ({res_val, invalid, is_nan} !== exp) begin
            errors++;
            $display("FAIL %s: got val=%h inv=%b nan=%b expected val=%h inv=%b nan=%b",
                     req, res_val, invalid, is_nan, exp[65:2], exp[1], exp[0]);
        end
    endtask

    task automatic apply(logic [63:0] v, logic [1:0] sf, logic [1:0] df, logic dm);
        @(negedge clk);
        src_val = v; src_fmt = sf; dst_fmt = df; dflt_mode = dm;
        @(negedge clk);
    endtask

    task automatic run(string req, logic [63:0] v, logic [1:0] sf,
                       logic [1:0] df, logic dm, logic [65:0] exp);
        apply(v, sf, df, dm);
        check(req, exp);
        if (exp !== model(v, sf, df, dm)) begin
            checks++; errors++;
            $display("FAIL %s: bench model %h disagrees with directed %h",
                     req, model(v, sf, df, dm), exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        src_val = 64'h7FF0_0000_0000_0001;
        src_fmt = 2'd2;
        repeat (3) @(negedge clk);
        check("R8 reset", 66'd0);
        rst = 1'b0;

        // R5 R4 R2: half sNaN widened keeps signaling payload
        run("R5", 64'h7C01, 2'd0, 2'd1, 1'b0, {64'h7F80_2000, 1'b1, 1'b1});
        // R6: double payload truncates to zero in half
        run("R6", 64'h7FF0_0000_0000_0001, 2'd2, 2'd0, 1'b0, {64'h7E00, 1'b1, 1'b1});
        // R4: negative single qNaN to double
        run("R4", 64'hFFC0_0001, 2'd1, 2'd2, 1'b0, {64'hFFF8_0000_2000_0000, 1'b0, 1'b1});
        // R7: default mode still flags sNaN
        run("R7", 64'h7F80_0001, 2'd1, 2'd0, 1'b1, {64'h7E00, 1'b1, 1'b1});
        // R3: ordinary double passes through, also in default mode
        run("R3", 64'h3FF0_0000_0000_0000, 2'd2, 2'd0, 1'b1,
            {64'h3FF0_0000_0000_0000, 1'b0, 1'b0});
        // R1: half infinity with junk above is not a NaN
        run("R1", 64'hABCD_0000_0000_7C00, 2'd0, 2'd1, 1'b0,
            {64'hABCD_0000_0000_7C00, 1'b0, 1'b0});
        // R1: junk above a half NaN ignored by decode
        run("R1", 64'hFFFF_FFFF_FFFF_7E01, 2'd0, 2'd0, 1'b0, {64'h7E01, 1'b0, 1'b1});
        // R1: reserved code decodes as double
        run("R1", 64'h7FF4_0000_0000_0000, 2'd3, 2'd3, 1'b0,
            {64'h7FF4_0000_0000_0000, 1'b1, 1'b1});
        // R2: pulse drops when next operand is quiet
        run("R2", 64'h7FC0_0000, 2'd1, 2'd1, 1'b0, {64'h7FC0_0000, 1'b0, 1'b1});
        // R9: single to half keeps top fraction bits
        run("R9", 64'h7FAA_AAAA, 2'd1, 2'd0, 1'b0, {64'h7D55, 1'b1, 1'b1});
        // R8: one-cycle latency, result follows the vector just applied
        apply(64'h7E00, 2'd0, 2'd2, 1'b0);
        check("R8 latency", {64'h7FF8_0000_0000_0000, 1'b0, 1'b1});

        for (int n = 0; n < 600; n++) begin
            logic [63:0] v  = {$urandom, $urandom};
            logic [1:0]  sf = 2'($urandom_range(0, 3));
            logic [1:0]  df = 2'($urandom_range(0, 3));
            logic        dm = ($urandom_range(0, 3) == 0);
            int          k  = $urandom_range(0, 3);
            int          ew = b_ew(sf);
            int          fw = b_fw(sf);
            logic [65:0] e;
            string       tag;
            if (k < 3) begin
                v = v | (b_mask(ew) << fw);
                if (k == 1) v[fw-1] = 1'b0;
                if (k == 2) v = v & ~(b_mask(fw - 8));
            end
            e = model(v, sf, df, dm);
            tag = !e[0] ? "R3" : dm ? "R7" : e[1] ? "R2" : "R9";
            apply(v, sf, df, dm);
            check(tag, e);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule